// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Day-Resolution Alarm

This block keeps wall-clock time from a one-cycle pulse that arrives once per second. Seconds, minutes and hours are held as two-digit BCD values. Whole days are held as a 15-bit binary count. A byte-wide register file gives software read and write access to the counters, three alarm compare values (minute, hour, day) and a control byte.

Each alarm field has its own match enable. The alarm flag is set when the seconds field rolls from 59 to 00 and every enabled field equals the freshly updated count. If no field is enabled, every minute boundary matches. Software clears the flag by writing 1 to its bit. The interrupt output is the flag gated by an interrupt enable. While a tick is updating the counters, a busy bit in the control byte reads 1. Software can then discard a read that was taken during a rollover.

Reads are combinational from the current register state. Writes take effect at the clock edge on which `we_i` is high.

Top module: `rtc_bcd_cal`

## Requirements
- R1: While reset is asserted and directly after it is released, every register reads 0x00 and `irq_o` is low.
- R2: Register map (4-bit address): 0 control, 1 seconds, 2 minutes, 3 hours, 4 day bits 7:0, 5 day bits 14:8, 6 alarm minutes, 7 alarm hours, 8 alarm day bits 7:0, 9 alarm day bits 14:8. The day-high registers store `wdata_i[6:0]` and read bit 7 as 0. The time and alarm byte registers read back exactly what was written.
- R3: On each counted tick, seconds count in BCD from 0x00 to 0x59 and then wrap to 0x00 with a carry into minutes. Minutes count the same way and carry into hours.
- R4: Hours count in BCD from 0x00 to 0x23, then wrap to 0x00 with a carry into the day count.
- R5: The day count is a 15-bit binary value that increments on each hour carry and wraps from 0x7FFF to 0.
- R6: A BCD field whose raw byte is at or above its limit wraps to 0x00 and carries on its next increment. A units digit of 9 or more becomes 0 and increments the tens digit. No value stalls the count.
- R7: Control bit 0 (run) gates counting. While run is 0, ticks change no counter.
- R8: Control bit 7 (busy, read-only) reads 1 exactly in a cycle where `tick_i` is high and run is 1, and reads 0 otherwise.
- R9: Control bits 1, 2 and 3 enable the minute, hour and day match. The flag (control bit 5) sets on a tick where seconds wrap, when each enabled field equals its updated count. The compare uses the enables and alarm values held before that edge. Disabled fields are ignored.
- R10: Writing control with bit 5 = 1 clears the flag. Writing bit 5 = 0 leaves the flag unchanged. If an alarm match and a clear happen in the same cycle, the flag stays set.
- R11: Control bit 4 is the interrupt enable. `irq_o` is high exactly when the flag and the interrupt enable are both 1.
- R12: When a tick and a write to a counter land in the same cycle, the written field takes the written value. The carry out of that field is still computed from its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The hardest case to reach from the ports is a full cascade: one tick that rolls seconds, minutes, hours and the day count together, including the day wrap from 0x7FFF. The bench avoids tens of thousands of ticks by writing the counters to their edge values and then sending a single tick. It uses the same approach to create an alarm match and a flag clear in the same cycle, and a counter write in the same cycle as a tick. A behavioural model then follows thousands of ticks with varied read addresses, comparing every clock.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTL        = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEC        = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN        = 4'd2;
  localparam logic [ADDR_W-1:0] A_HOUR       = 4'd3;
  localparam logic [ADDR_W-1:0] A_DAY_LO     = 4'd4;
  localparam logic [ADDR_W-1:0] A_DAY_HI     = 4'd5;
  localparam logic [ADDR_W-1:0] A_ALM_MIN    = 4'd6;
  localparam logic [ADDR_W-1:0] A_ALM_HOUR   = 4'd7;
  localparam logic [ADDR_W-1:0] A_ALM_DAY_LO = 4'd8;
  localparam logic [ADDR_W-1:0] A_ALM_DAY_HI = 4'd9;

  localparam int CTL_RUN  = 0;
  localparam int CTL_MEN  = 1;
  localparam int CTL_HEN  = 2;
  localparam int CTL_DEN  = 3;
  localparam int CTL_IEN  = 4;
  localparam int CTL_FLG  = 5;
  localparam int CTL_BUSY = 7;

  localparam int N_BCD = 3;
  localparam logic [N_BCD-1:0][7:0] BCD_LIMITS = {8'h23, 8'h59, 8'h59};
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] LIMIT = 8'h59
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] val_o,
  output logic [7:0] nxt_o,
  output logic       carry_o
);
  logic [7:0] val_q, inc_val;
  logic       at_top;

  always_comb begin
    // raw compare: any out-of-range byte also counts as "at top"
    at_top = (val_q >= LIMIT);
    if (at_top)                  inc_val = 8'h00;
    else if (val_q[3:0] >= 4'd9) inc_val = {val_q[7:4] + 4'd1, 4'h0};
    else                         inc_val = {val_q[7:4], val_q[3:0] + 4'd1};
    carry_o = inc_i && at_top;
    if (ld_i)       nxt_o = ld_val_i;
    else if (inc_i) nxt_o = inc_val;
    else            nxt_o = val_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= 8'h00;
    else         val_q <= nxt_o;
  end

  assign val_o = val_q;

  // R6
  wrap_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && val_q >= LIMIT) |=> (val_q == 8'h00));
  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && val_q < LIMIT) |=> (val_q != $past(val_q)));
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(val_q));
endmodule

// File: rtl/rtc_day_cnt.sv
module rtc_day_cnt #(
  parameter int DAY_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             ld_lo_i,
  input  logic             ld_hi_i,
  input  logic [7:0]       wdata_i,
  output logic [DAY_W-1:0] val_o,
  output logic [DAY_W-1:0] nxt_o
);
  localparam int HI_W = DAY_W - 8;
  localparam logic [DAY_W-1:0] DAY_MAX = {DAY_W{1'b1}};

  logic [DAY_W-1:0] val_q;

  always_comb begin
    nxt_o = inc_i ? val_q + 1'b1 : val_q;
    if (ld_lo_i) nxt_o[7:0]       = wdata_i;
    if (ld_hi_i) nxt_o[DAY_W-1:8] = wdata_i[HI_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= nxt_o;
  end

  assign val_o = val_q;

  // R5
  day_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_lo_i && !ld_hi_i && val_q == DAY_MAX) |=> (val_q == '0));
  // R5
  day_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_lo_i && !ld_hi_i && val_q != DAY_MAX) |=> (val_q == $past(val_q) + 1'b1));
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int DAY_W = 15
) (
  input  logic             men_i,
  input  logic             hen_i,
  input  logic             den_i,
  input  logic [7:0]       min_i,
  input  logic [7:0]       hour_i,
  input  logic [DAY_W-1:0] day_i,
  input  logic [7:0]       alm_min_i,
  input  logic [7:0]       alm_hour_i,
  input  logic [DAY_W-1:0] alm_day_i,
  output logic             match_o
);
  logic min_ok, hour_ok, day_ok;

  always_comb begin
    min_ok  = !men_i || (min_i == alm_min_i);
    hour_ok = !hen_i || (hour_i == alm_hour_i);
    day_ok  = !den_i || (day_i == alm_day_i);
    match_o = min_ok && hour_ok && day_ok;
  end
endmodule

// File: rtl/rtc_bcd_cal.sv
module rtc_bcd_cal
  import rtc_cal_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  localparam int HI_W = DAY_W - 8;

  logic run_q, men_q, hen_q, den_q, ien_q, flag_q;
  logic [7:0] alm_min_q, alm_hour_q;
  logic [DAY_W-1:0] alm_day_q;

  logic       fld_inc   [N_BCD];
  logic       fld_carry [N_BCD];
  logic [7:0] fld_val   [N_BCD];
  logic [7:0] fld_nxt   [N_BCD];

  logic [DAY_W-1:0] day_val, day_nxt;
  logic wr_ctl, busy, alarm_match, alarm_hit;

  assign wr_ctl = we_i && (addr_i == A_CTL);
  assign busy   = tick_i && run_q;

  for (genvar g = 0; g < N_BCD; g++) begin : g_fld
    localparam logic [ADDR_W-1:0] FLD_ADDR = A_SEC + ADDR_W'(g);
    if (g == 0) begin : g_src
      assign fld_inc[g] = busy;
    end else begin : g_src
      assign fld_inc[g] = fld_carry[g-1];
    end
    rtc_bcd_field #(.LIMIT(BCD_LIMITS[g])) u_fld (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (fld_inc[g]),
      .ld_i     (we_i && (addr_i == FLD_ADDR)),
      .ld_val_i (wdata_i),
      .val_o    (fld_val[g]),
      .nxt_o    (fld_nxt[g]),
      .carry_o  (fld_carry[g])
    );
  end

  rtc_day_cnt #(.DAY_W(DAY_W)) u_day (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (fld_carry[N_BCD-1]),
    .ld_lo_i (we_i && (addr_i == A_DAY_LO)),
    .ld_hi_i (we_i && (addr_i == A_DAY_HI)),
    .wdata_i (wdata_i),
    .val_o   (day_val),
    .nxt_o   (day_nxt)
  );

  rtc_alarm_cmp #(.DAY_W(DAY_W)) u_cmp (
    .men_i      (men_q),
    .hen_i      (hen_q),
    .den_i      (den_q),
    .min_i      (fld_nxt[1]),
    .hour_i     (fld_nxt[2]),
    .day_i      (day_nxt),
    .alm_min_i  (alm_min_q),
    .alm_hour_i (alm_hour_q),
    .alm_day_i  (alm_day_q),
    .match_o    (alarm_match)
  );

  // alarm evaluated only on the minute boundary
  assign alarm_hit = fld_carry[0] && alarm_match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; men_q <= 1'b0; hen_q <= 1'b0; den_q <= 1'b0; ien_q <= 1'b0;
      flag_q <= 1'b0;
      alm_min_q <= 8'h00; alm_hour_q <= 8'h00; alm_day_q <= '0;
    end else begin
      if (wr_ctl) begin
        run_q <= wdata_i[CTL_RUN];
        men_q <= wdata_i[CTL_MEN];
        hen_q <= wdata_i[CTL_HEN];
        den_q <= wdata_i[CTL_DEN];
        ien_q <= wdata_i[CTL_IEN];
      end
      if (alarm_hit)                        flag_q <= 1'b1;
      else if (wr_ctl && wdata_i[CTL_FLG])  flag_q <= 1'b0;
      if (we_i && addr_i == A_ALM_MIN)    alm_min_q  <= wdata_i;
      if (we_i && addr_i == A_ALM_HOUR)   alm_hour_q <= wdata_i;
      if (we_i && addr_i == A_ALM_DAY_LO) alm_day_q[7:0] <= wdata_i;
      if (we_i && addr_i == A_ALM_DAY_HI) alm_day_q[DAY_W-1:8] <= wdata_i[HI_W-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      A_CTL:        rdata_o = {busy, 1'b0, flag_q, ien_q, den_q, hen_q, men_q, run_q};
      A_SEC:        rdata_o = fld_val[0];
      A_MIN:        rdata_o = fld_val[1];
      A_HOUR:       rdata_o = fld_val[2];
      A_DAY_LO:     rdata_o = day_val[7:0];
      A_DAY_HI:     rdata_o = 8'(day_val >> 8);
      A_ALM_MIN:    rdata_o = alm_min_q;
      A_ALM_HOUR:   rdata_o = alm_hour_q;
      A_ALM_DAY_LO: rdata_o = alm_day_q[7:0];
      A_ALM_DAY_HI: rdata_o = 8'(alm_day_q >> 8);
      default:      rdata_o = 8'h00;
    endcase
  end

  assign irq_o = flag_q && ien_q;

  // R9
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_hit |=> flag_q);
  // R10
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctl && wdata_i[CTL_FLG] && !alarm_hit) |=> !flag_q);
  // R10
  flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_ctl && wdata_i[CTL_FLG])) |=> flag_q);
  // R8
  busy_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CTL && !tick_i) |-> !rdata_o[CTL_BUSY]);
  // R11
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(alarm_hit) || $past(wr_ctl)));
endmodule

// File: tb/rtc_bcd_cal_tb_top.sv
`timescale 1ns/100ps
module rtc_bcd_cal_tb_top;
  import rtc_cal_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq;

  always #4 clk = ~clk;

  rtc_bcd_cal dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int m_sec = 0, m_min = 0, m_hr = 0, m_day = 0, m_amin = 0, m_ahr = 0, m_aday = 0;
  bit m_run = 0, m_men = 0, m_hen = 0, m_den = 0, m_ien = 0, m_flag = 0;

  function automatic int bcd_inc(int v, int lim);
    if (v >= lim) return 0;
    if ((v % 16) >= 9) return (v / 16 + 1) * 16;
    return v + 1;
  endfunction

  function automatic int model_read(int a, bit t);
    case (a)
      0: return m_run + 2*m_men + 4*m_hen + 8*m_den + 16*m_ien + 32*m_flag + ((t && m_run) ? 128 : 0);
      1: return m_sec;
      2: return m_min;
      3: return m_hr;
      4: return m_day % 256;
      5: return m_day / 256;
      6: return m_amin;
      7: return m_ahr;
      8: return m_aday % 256;
      9: return m_aday / 256;
      default: return 0;
    endcase
  endfunction

  task automatic model_update(bit t, bit w, int a, int d);
    int ns, nm, nh, nd;
    bit cnt, c0, c1, c2, hit;
    cnt = t && m_run;
    c0 = cnt && (m_sec >= 'h59);
    c1 = c0 && (m_min >= 'h59);
    c2 = c1 && (m_hr >= 'h23);
    ns = cnt ? bcd_inc(m_sec, 'h59) : m_sec;
    nm = c0 ? bcd_inc(m_min, 'h59) : m_min;
    nh = c1 ? bcd_inc(m_hr, 'h23) : m_hr;
    nd = c2 ? (m_day + 1) % 32768 : m_day;
    if (w) begin
      case (a)
        1: ns = d;
        2: nm = d;
        3: nh = d;
        4: nd = (nd / 256) * 256 + d;
        5: nd = (d % 128) * 256 + nd % 256;
        default: ;
      endcase
    end
    hit = c0 && (!m_men || nm == m_amin) && (!m_hen || nh == m_ahr) && (!m_den || nd == m_aday);
    if (hit) m_flag = 1;
    else if (w && a == 0 && ((d / 32) % 2 == 1)) m_flag = 0;
    if (w) begin
      case (a)
        0: begin
          m_run = d % 2; m_men = (d / 2) % 2; m_hen = (d / 4) % 2;
          m_den = (d / 8) % 2; m_ien = (d / 16) % 2;
        end
        6: m_amin = d;
        7: m_ahr = d;
        8: m_aday = (m_aday / 256) * 256 + d;
        9: m_aday = (d % 128) * 256 + m_aday % 256;
        default: ;
      endcase
    end
    m_sec = ns; m_min = nm; m_hr = nh; m_day = nd;
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit t, bit w, int a, int d, int lit, string req);
    @(negedge clk);
    tick = t; we = w; addr = a[ADDR_W-1:0]; wdata = d[7:0];
    #1;
    check(req, "rdata", int'(rdata), model_read(a, t));
    if (lit >= 0) check(req, "rdata_literal", int'(rdata), lit);
    check(req, "irq", int'(irq), int'(m_flag && m_ien));
    @(posedge clk);
    model_update(t, w, a, d);
  endtask

  task automatic wr(int a, int d, string req);
    step(0, 1, a, d, -1, req);
  endtask

  task automatic rd(int a, int lit, string req);
    step(0, 0, a, 0, lit, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 10; a++) begin
      addr = a[ADDR_W-1:0];
      #0.3;
      check("R1", "reset_rdata", int'(rdata), 0);
    end
    check("R1", "reset_irq", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 10; a++) rd(a, 0, "R1");

    // R2 map and readback
    wr(1, 'h58, "R2"); wr(2, 'h59, "R2"); wr(3, 'h23, "R2");
    wr(4, 'hFF, "R2"); wr(5, 'hFF, "R2");
    wr(6, 'h01, "R2"); wr(7, 'h02, "R2"); wr(8, 'h34, "R2"); wr(9, 'h92, "R2");
    rd(1, 'h58, "R2"); rd(5, 'h7F, "R2"); rd(9, 'h12, "R2"); rd(8, 'h34, "R2");

    // R8 busy, R3/R4/R5 full cascade, R9 vacuous match
    wr(0, 'h01, "R7");
    step(1, 0, 0, 0, 'h81, "R8");
    step(1, 0, 1, 0, 'h59, "R3");
    rd(1, 'h00, "R3"); rd(2, 'h00, "R3"); rd(3, 'h00, "R4");
    rd(4, 'h00, "R5"); rd(5, 'h00, "R5");
    rd(0, 'h21, "R9");
    wr(0, 'h21, "R10");
    rd(0, 'h01, "R10");

    // R7 run off ignores ticks
    wr(0, 'h00, "R7");
    step(1, 0, 0, 0, 'h00, "R8");
    for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 'h00, "R7");
    rd(1, 'h00, "R7");

    // R6 out-of-range digits
    wr(0, 'h01, "R6");
    wr(1, 'h5A, "R6");
    step(1, 0, 1, 0, 'h5A, "R6");
    rd(1, 'h00, "R6"); rd(2, 'h01, "R6");
    wr(1, 'h0F, "R6");
    step(1, 0, 1, 0, 'h0F, "R6");
    rd(1, 'h10, "R6");
    wr(3, 'h3F, "R6"); wr(2, 'h59, "R6"); wr(1, 'h59, "R6");
    step(1, 0, 3, 0, 'h3F, "R6");
    rd(1, 'h00, "R6"); rd(2, 'h00, "R6"); rd(3, 'h00, "R4"); rd(4, 'h01, "R6");

    // R9 minute match
    wr(6, 'h02, "R9"); wr(7, 'h00, "R9"); wr(8, 'h01, "R9"); wr(9, 'h00, "R9");
    wr(0, 'h23, "R10");
    rd(0, 'h03, "R10");
    for (int i = 0; i < 119; i++) step(1, 0, i % 10, 0, -1, "R3");
    rd(0, 'h03, "R9");
    step(1, 0, 2, 0, 'h01, "R9");
    rd(0, 'h23, "R9");
    check("R11", "irq_masked", int'(irq), 0);
    wr(0, 'h13, "R10");
    rd(0, 'h33, "R10");
    check("R11", "irq_enabled", int'(irq), 1);

    // R10 set wins over clear
    wr(0, 'h33, "R10");
    rd(0, 'h13, "R10");
    wr(6, 'h03, "R10"); wr(1, 'h59, "R10");
    step(1, 1, 0, 'h33, 'h93, "R10");
    rd(0, 'h33, "R10");

    // R9 hour mismatch blocks match
    wr(0, 'h37, "R9"); wr(7, 'h05, "R9"); wr(2, 'h02, "R9"); wr(1, 'h59, "R9");
    step(1, 0, 1, 0, 'h59, "R9");
    rd(2, 'h03, "R9"); rd(0, 'h17, "R9");
    // all three enabled and equal
    wr(7, 'h00, "R9"); wr(0, 'h1F, "R9"); wr(2, 'h02, "R9"); wr(1, 'h59, "R9");
    step(1, 0, 1, 0, 'h59, "R9");
    rd(0, 'h3F, "R9");
    check("R11", "irq_set", int'(irq), 1);
    // day mismatch
    wr(0, 'h3F, "R10"); wr(8, 'h02, "R9"); wr(2, 'h02, "R9"); wr(1, 'h59, "R9");
    step(1, 0, 1, 0, 'h59, "R9");
    rd(0, 'h1F, "R9");
    check("R11", "irq_clear", int'(irq), 0);

    // R12 write during tick
    wr(1, 'h59, "R12"); wr(2, 'h10, "R12");
    step(1, 1, 1, 'h30, 'h59, "R12");
    rd(1, 'h30, "R12"); rd(2, 'h11, "R12");

    // long run against the model
    wr(0, 'h01, "R3");
    wr(2, 'h58, "R4"); wr(3, 'h23, "R4");
    for (int i = 0; i < 3700; i++) step((i % 4) != 3, 0, i % 10, 0, -1, "R4");
    wr(0, 'h00, "R7");
    for (int i = 0; i < 10; i++) rd(i, -1, "R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule